// File: doc/BRIEF.md
# Interrupt Line Port Router

This block sits in a chip's system-configuration space and decides which GPIO port drives each of sixteen external-interrupt lines. Nine ports of sixteen pins each arrive as one flat 144-bit vector. Output line n can only ever carry pin n, and a 4-bit port selector, one per line, names the single port whose pin n is forwarded. Pin activity on every other port is discarded for that line.

Software programs the selectors through a 32-bit register window of 0x400 bytes. Four selector registers each pack four line fields. The window also holds a memory-remap word and a peripheral-mode word, which read as zero and ignore writes. A 32-bit compensation-control word stores whatever is written to it. Each output is a flop holding the last forwarded level. It moves only when the selected pin itself changes, so reprogramming a selector never produces a spurious level on the line.

Top module: `irq_port_router`

## Requirements
- R1: After reset every register reads zero, every selector field therefore names port 0, and all 16 line outputs are low.
- R2: Line n is updated to the level of pin n of the port named by its selector field, at the first rising clock edge after that pin changes. The selector field sits in the register at offset 0x08 + 4*(n/4), bits 4*(n%4)+3 down to 4*(n%4).
- R3: A level change on pin n of any port other than the one selected for line n leaves line n unchanged.
- R4: A write to a selector register (offsets 0x08, 0x0C, 0x10, 0x14) keeps only data bits 15:0. Bits 31:16 of a read from that register are zero.
- R5: Writes to the remap word (0x00) and the mode word (0x04) are ignored, and both always read zero.
- R6: The compensation-control word at offset 0x20 stores and returns all 32 written bits.
- R7: Reads from any other offset in the window return zero, and writes there change no register.
- R8: A selector write does not by itself change any line output, even when the newly selected pin differs from the line's level.
- R9: A line whose selector field holds 9 to 15 names no port and keeps its level whatever the pins do.
- R10: Pin p of port k is input bit k*16 + p of the pin vector, so port 8 pin 15 is bit 143.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Register write strobe for the current address |
| addr | input | 10 | Byte offset in the register window; bits 1:0 ignored |
| wrData | input | 32 | Register write data |
| rdData | output | 32 | Read data for the current address, combinational |
| pinIn | input | 144 | Port pin levels, bit k*16+p is port k pin p |
| lineOut | output | 16 | Interrupt line levels |

## Verification
The bench builds the block with its defaults, nine ports and a ten-bit window. With these defaults the top port (8) and the top pin bit (143) can be exercised, and the seven field codes 9 to 15 that name no port can be tested as dead selections. A register table sweeps selectors, the ignored words, the compensation word and unmapped offsets. Directed routing tests then reselect a line while its old and new pins disagree, which separates forwarding on a pin change from forwarding on a selector write.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam int LINES          = 16;
  localparam int FIELD_W        = 4;
  localparam int FIELDS_PER_REG = 4;
  localparam int NUM_SEL        = LINES / FIELDS_PER_REG;
  localparam int SEL_KEEP       = FIELD_W * FIELDS_PER_REG;
  localparam int DATA_W         = 32;
  localparam int IDX_W          = $clog2(NUM_SEL);

  // word indices (byte offset / 4)
  localparam int WORD_REMAP    = 0;
  localparam int WORD_MODE     = 1;
  localparam int WORD_SEL_BASE = 2;
  localparam int WORD_COMP     = 8;

  typedef enum logic [1:0] {
    RD_ZERO = 2'd0,
    RD_SEL  = 2'd1,
    RD_COMP = 2'd2
  } rdSrc_e;

  typedef struct packed {
    logic [NUM_SEL-1:0] selWr;
    logic               compWr;
    rdSrc_e             rdSrc;
    logic [IDX_W-1:0]   rdIdx;
  } regStrobe_t;
endpackage

// File: rtl/irq_router_ctrl.sv
module irq_router_ctrl
  import irq_router_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  output regStrobe_t        strobe
);
  localparam int WORD_W = ADDR_W - 2;
  localparam logic [WORD_W-1:0] SEL_FIRST = WORD_W'(WORD_SEL_BASE);
  localparam logic [WORD_W-1:0] SEL_LAST  = WORD_W'(WORD_SEL_BASE + NUM_SEL - 1);
  localparam logic [WORD_W-1:0] COMP_IDX  = WORD_W'(WORD_COMP);
  localparam logic [WORD_W-1:0] REMAP_IDX = WORD_W'(WORD_REMAP);
  localparam logic [WORD_W-1:0] MODE_IDX  = WORD_W'(WORD_MODE);

  logic [WORD_W-1:0] wordIdx;
  logic [WORD_W-1:0] selOff;
  logic              unusedLow;

  assign wordIdx   = addr[ADDR_W-1:2];
  assign selOff    = wordIdx - SEL_FIRST;
  assign unusedLow = ^addr[1:0];

  always_comb begin
    strobe        = '0;
    strobe.rdSrc  = RD_ZERO;
    if (wordIdx >= SEL_FIRST && wordIdx <= SEL_LAST) begin
      strobe.rdSrc = RD_SEL;
      strobe.rdIdx = selOff[IDX_W-1:0];
      strobe.selWr[selOff[IDX_W-1:0]] = wrEn;
    end else if (wordIdx == COMP_IDX) begin
      strobe.rdSrc  = RD_COMP;
      strobe.compWr = wrEn;
    end
  end

  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.selWr, strobe.compWr})); // R7

  AST_FIXED_WORDS_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (wordIdx == REMAP_IDX || wordIdx == MODE_IDX) |->
      (strobe.selWr == '0 && !strobe.compWr && strobe.rdSrc == RD_ZERO)); // R5
endmodule

// File: rtl/irq_router_dp.sv
module irq_router_dp
  import irq_router_pkg::*;
#(
  parameter int NUM_PORTS = 9
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  regStrobe_t                 strobe,
  input  logic [DATA_W-1:0]          wrData,
  input  logic [NUM_PORTS*LINES-1:0] pinIn,
  output logic [DATA_W-1:0]          rdData,
  output logic [LINES-1:0]           lineOut
);
  localparam int PIN_W = NUM_PORTS * LINES;

  logic [SEL_KEEP-1:0] selReg [NUM_SEL];
  logic [DATA_W-1:0]   compReg;
  logic [PIN_W-1:0]    pinPrev;
  logic [LINES-1:0]    lineQ;
  logic [LINES-1:0]    lineHit;
  logic [LINES-1:0]    lineLvl;

  // selector storage
  for (genvar s = 0; s < NUM_SEL; s++) begin : gSel
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                selReg[s] <= '0;
      else if (strobe.selWr[s]) selReg[s] <= wrData[SEL_KEEP-1:0];
    end

    AST_SEL_LOW_HALF: assert property (@(posedge clk) disable iff (!rstN)
      $past(strobe.selWr[s]) |-> selReg[s] == $past(wrData[SEL_KEEP-1:0])); // R4
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              compReg <= '0;
    else if (strobe.compWr) compReg <= wrData;
  end

  AST_COMP_FULL: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobe.compWr) |-> compReg == $past(wrData)); // R6

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pinPrev <= '0;
    else       pinPrev <= pinIn;
  end

  // per-line port mux and change detect
  for (genvar n = 0; n < LINES; n++) begin : gLine
    localparam int REG_I = n / FIELDS_PER_REG;
    localparam int BIT_I = (n % FIELDS_PER_REG) * FIELD_W;

    logic [FIELD_W-1:0] field;
    assign field = selReg[REG_I][BIT_I +: FIELD_W];

    always_comb begin
      lineHit[n] = 1'b0;
      lineLvl[n] = 1'b0;
      for (int k = 0; k < NUM_PORTS; k++) begin
        if (int'(field) == k) begin
          lineHit[n] = pinIn[k*LINES+n] != pinPrev[k*LINES+n];
          lineLvl[n] = pinIn[k*LINES+n];
        end
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)           lineQ[n] <= 1'b0;
      else if (lineHit[n]) lineQ[n] <= lineLvl[n];
    end

    AST_LINE_FROM_SELECTED: assert property (@(posedge clk) disable iff (!rstN)
      (lineQ[n] != $past(lineQ[n])) |-> (lineQ[n] == $past(lineLvl[n]))); // R2

    AST_DEAD_FIELD_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
      (int'($past(field)) >= NUM_PORTS) |-> (lineQ[n] == $past(lineQ[n]))); // R9
  end

  assign lineOut = lineQ;

  always_comb begin
    unique case (strobe.rdSrc)
      RD_SEL:  rdData = DATA_W'(selReg[strobe.rdIdx]);
      RD_COMP: rdData = compReg;
      default: rdData = '0;
    endcase
  end
endmodule

// File: rtl/irq_port_router.sv
module irq_port_router
  import irq_router_pkg::*;
#(
  parameter int NUM_PORTS = 9,
  parameter int ADDR_W    = 10
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       wrEn,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [DATA_W-1:0]          wrData,
  output logic [DATA_W-1:0]          rdData,
  input  logic [NUM_PORTS*LINES-1:0] pinIn,
  output logic [LINES-1:0]           lineOut
);
  regStrobe_t strobe;

  irq_router_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .addr   (addr),
    .strobe (strobe)
  );

  irq_router_dp #(.NUM_PORTS(NUM_PORTS)) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .wrData  (wrData),
    .pinIn   (pinIn),
    .rdData  (rdData),
    .lineOut (lineOut)
  );
endmodule

// File: tb/sim_irq_port_router.sv
`timescale 1ns/1ps
module sim_irq_port_router;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         wrEn = 1'b0;
  logic [9:0]   addr = '0;
  logic [31:0]  wrData = '0;
  logic [31:0]  rdData;
  logic [143:0] pins = '0;
  logic [15:0]  lineOut;

  int checks = 0;
  int errors = 0;
  logic [31:0] rv;

  always #2 clk = ~clk;

  irq_port_router u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .pinIn(pins), .lineOut(lineOut)
  );

  // {address, write data, expected read}
  localparam logic [73:0] VEC [0:8] = '{
    {10'h008, 32'hDEAD_1234, 32'h0000_1234},
    {10'h00C, 32'hFFFF_FFFF, 32'h0000_FFFF},
    {10'h010, 32'h0001_5678, 32'h0000_5678},
    {10'h014, 32'h1234_ABCD, 32'h0000_ABCD},
    {10'h000, 32'hFFFF_FFFF, 32'h0000_0000},
    {10'h004, 32'h5555_5555, 32'h0000_0000},
    {10'h020, 32'hA5A5_5A5A, 32'hA5A5_5A5A},
    {10'h018, 32'hFFFF_FFFF, 32'h0000_0000},
    {10'h3FC, 32'h0000_1234, 32'h0000_0000}
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic regWrite(logic [9:0] a, logic [31:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic regRead(logic [9:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdData;
  endtask

  task automatic setPin(int idx, logic v);
    @(negedge clk);
    pins[idx] = v;
    @(negedge clk);
  endtask

  task automatic doReset();
    @(negedge clk);
    pins = '0;
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic checkAllZero();
    for (int a = 0; a < 10; a++) begin
      regRead(10'(a * 4), rv);
      check("R1 reg", rv, 32'h0);
    end
    check("R1 lines", {16'h0, lineOut}, 32'h0);
  endtask

  initial begin
    #(100000 * 4);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    doReset();
    checkAllZero();

    // register table: R4, R5, R6, R7
    for (int i = 0; i < 9; i++) begin
      string req;
      logic [9:0] a;
      a = VEC[i][73:64];
      if (a >= 10'h008 && a <= 10'h014) req = "R4";
      else if (a == 10'h000 || a == 10'h004) req = "R5";
      else if (a == 10'h020) req = "R6";
      else req = "R7";
      regWrite(a, VEC[i][63:32]);
      regRead(a, rv);
      check(req, rv, VEC[i][31:0]);
    end
    regRead(10'h008, rv);
    check("R7 unmapped write kept selector", rv, 32'h0000_1234);
    regRead(10'h020, rv);
    check("R7 unmapped write kept comp", rv, 32'hA5A5_5A5A);

    // R1: reset clears everything written above
    doReset();
    checkAllZero();

    // R2 / R10: port 0 pin 5 drives line 5 one edge later
    @(negedge clk);
    pins[5] = 1'b1;
    #1;
    check("R2 before edge", {31'h0, lineOut[5]}, 32'h0);
    @(negedge clk);
    check("R2 after edge", {31'h0, lineOut[5]}, 32'h1);

    // R8: reselect line 5 to port 3 (reg 0x0C bits 7:4), line holds high
    regWrite(10'h00C, 32'h0000_0030);
    @(negedge clk);
    check("R8 reselect no redrive", {31'h0, lineOut[5]}, 32'h1);

    // R3: old port 0 pin 5 falls, ignored
    setPin(5, 1'b0);
    check("R3 unselected port ignored", {31'h0, lineOut[5]}, 32'h1);

    // R2: port 3 pin 5 (bit 53) rises then falls
    setPin(3*16+5, 1'b1);
    check("R2 selected high", {31'h0, lineOut[5]}, 32'h1);
    setPin(3*16+5, 1'b0);
    check("R2 selected low", {31'h0, lineOut[5]}, 32'h0);

    // R10: port 8 pin 15 (bit 143) on line 15, reg 0x14 bits 15:12
    regWrite(10'h014, 32'h0000_8000);
    setPin(143, 1'b1);
    check("R10 top bit to line 15", {31'h0, lineOut[15]}, 32'h1);
    check("R3 other lines quiet", {16'h0, lineOut & 16'h7FFF}, 32'h0);

    // R9: line 0 field = 9, then 15; all ports pin 0 toggle
    regWrite(10'h008, 32'h0000_0009);
    for (int k = 0; k < 9; k++) setPin(k*16, 1'b1);
    check("R9 field 9 holds", {31'h0, lineOut[0]}, 32'h0);
    regWrite(10'h008, 32'h0000_000F);
    for (int k = 0; k < 9; k++) setPin(k*16, 1'b0);
    for (int k = 0; k < 9; k++) setPin(k*16, 1'b1);
    check("R9 field 15 holds", {31'h0, lineOut[0]}, 32'h0);

    // R2: back to port 8 for line 0, toggle its pin 0 (bit 128)
    regWrite(10'h008, 32'h0000_0008);
    setPin(128, 1'b0);
    check("R2 port 8 line 0 low", {31'h0, lineOut[0]}, 32'h0);
    setPin(128, 1'b1);
    check("R2 port 8 line 0 high", {31'h0, lineOut[0]}, 32'h1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule